// File: doc/BRIEF.md
# Store-Load Overlap Detector

This block keeps a small record of the stores sent out during the current dispatch group and tells the scheduler, in the same cycle, whether a load it is about to place would touch bytes that one of those stores writes. Every memory access is described by three fields: a base identifier, a signed byte offset from that base, and a byte count.

When a store strobe arrives with a valid memory description, the store is written into the next free slot. A load query is compared against all occupied slots at once, and the single conflict bit is driven combinationally from the query inputs. A group-end strobe empties the record. Accesses without a valid memory description are never recorded, and they never raise a conflict.

Top module: `store_overlap_det`

## Requirements
- R1: At most DEPTH (default 4) stores are held per group, filled in arrival order. A store that arrives while DEPTH are held is dropped, and it never produces a conflict.
- R2: A load whose base and offset both equal those of a held store conflicts, whatever the two sizes are (including zero).
- R3: For a held store with the same base and an offset below the load offset, the load conflicts if and only if store offset plus store size is greater than the load offset.
- R4: For a held store with the same base and an offset at or above the load offset, the load conflicts if and only if load offset plus load size is greater than the store offset.
- R5: A held store whose base differs from the load base never produces a conflict.
- R6: `conflict_o` is 0 unless `ld_vld_i` and `ld_desc_ok_i` are both 1 and at least one store is held. This includes the state right after reset.
- R7: A cycle with `grp_end_i` high empties the record from the next cycle on. A store strobed in that same cycle is not kept.
- R8: Offsets are signed two's complement values, and the end-offset sums are formed one bit wider, so an access near the top of the offset range does not wrap around.
- R9: A store strobed with `st_desc_ok_i` low is not recorded.
- R10: `conflict_o` follows the load inputs in the same cycle. A store strobed in the same cycle as a load becomes visible only from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_end_i | input | 1 | Dispatch group ends; empties the store record |
| st_vld_i | input | 1 | Store issued this cycle |
| st_desc_ok_i | input | 1 | Store carries a valid memory description |
| st_base_i | input | BASE_W (4) | Store base identifier |
| st_off_i | input | OFF_W (16) | Store signed byte offset |
| st_size_i | input | SIZE_W (8) | Store byte count |
| ld_vld_i | input | 1 | Load query this cycle |
| ld_desc_ok_i | input | 1 | Load carries a valid memory description |
| ld_base_i | input | BASE_W (4) | Load base identifier |
| ld_off_i | input | OFF_W (16) | Load signed byte offset |
| ld_size_i | input | SIZE_W (8) | Load byte count |
| conflict_o | output | 1 | Load overlaps a held store |

## Verification
The hardest state to reach from the ports is a full record followed by a dropped fifth store that the next load matches exactly. Random traffic rarely produces five stores in one group and then aims a load at the fifth. Directed steps therefore fill the record on one base, send the fifth store, and query both the dropped store and a kept one. Random cycles draw bases and offsets from a narrow window so that overlaps and exact hits happen often. Directed accesses placed at the positive edge of the offset range exercise the widened sums.

// File: rtl/sold_pkg.sv
package sold_pkg;

    parameter int BASE_W = 4;
    parameter int OFF_W  = 16;
    parameter int SIZE_W = 8;

    // Sum width: wide enough for sign-extended offset plus zero-extended size
    localparam int SUM_W = ((OFF_W > SIZE_W) ? OFF_W : (SIZE_W + 1)) + 1;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [OFF_W-1:0]  off;
        logic [SIZE_W-1:0] size;
    } acc_t;

endpackage

// File: rtl/sold_store_tab.sv
module sold_store_tab
    import sold_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_i,
    input  logic                 wr_i,
    input  acc_t                 wr_acc_i,
    output acc_t [DEPTH-1:0]     ent_o,
    output logic [DEPTH-1:0]     vld_o
);

    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CW-1:0]    cnt;
        logic [DEPTH-1:0] vld;
        acc_t [DEPTH-1:0] ent;
    } tab_t;

    tab_t tab_d, tab_q;

    always_comb begin
        tab_d = tab_q;
        if (clr_i) begin
            tab_d.cnt = '0;
            tab_d.vld = '0;
        end else if (wr_i && (tab_q.cnt < CW'(DEPTH))) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == tab_q.cnt) begin
                    tab_d.ent[i] = wr_acc_i;
                    tab_d.vld[i] = 1'b1;
                end
            end
            tab_d.cnt = tab_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    assign ent_o = tab_q.ent;
    assign vld_o = tab_q.vld;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        tab_q.cnt <= CW'(DEPTH)); // R1
    AST_VLD_MATCH_CNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tab_q.vld) == int'(tab_q.cnt)); // R1
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tab_q.cnt == CW'(DEPTH) && !clr_i) |=> (tab_q.cnt == CW'(DEPTH))); // R1
    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (tab_q.vld == '0)); // R7
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !wr_i) |=> $stable(tab_q.vld)); // R9

endmodule

// File: rtl/sold_cmp.sv
module sold_cmp
    import sold_pkg::*;
(
    input  logic en_i,
    input  acc_t st_i,
    input  acc_t ld_i,
    output logic hit_o
);

    logic signed [SUM_W-1:0] st_lo, ld_lo, st_hi, ld_hi;
    logic same_base, exact, st_below, span_hit;

    always_comb begin
        st_lo = {{(SUM_W-OFF_W){st_i.off[OFF_W-1]}}, st_i.off};
        ld_lo = {{(SUM_W-OFF_W){ld_i.off[OFF_W-1]}}, ld_i.off};
        st_hi = st_lo + $signed({{(SUM_W-SIZE_W){1'b0}}, st_i.size});
        ld_hi = ld_lo + $signed({{(SUM_W-SIZE_W){1'b0}}, ld_i.size});

        same_base = (st_i.base == ld_i.base);
        exact     = same_base && (st_i.off == ld_i.off);
        st_below  = (st_lo < ld_lo);
        span_hit  = st_below ? (st_hi > ld_lo) : (ld_hi > st_lo);
        hit_o     = en_i && same_base && (exact || span_hit);
    end

endmodule

// File: rtl/store_overlap_det.sv
module store_overlap_det
    import sold_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grp_end_i,
    input  logic              st_vld_i,
    input  logic              st_desc_ok_i,
    input  logic [BASE_W-1:0] st_base_i,
    input  logic [OFF_W-1:0]  st_off_i,
    input  logic [SIZE_W-1:0] st_size_i,
    input  logic              ld_vld_i,
    input  logic              ld_desc_ok_i,
    input  logic [BASE_W-1:0] ld_base_i,
    input  logic [OFF_W-1:0]  ld_off_i,
    input  logic [SIZE_W-1:0] ld_size_i,
    output logic              conflict_o
);

    acc_t             st_acc, ld_acc;
    acc_t [DEPTH-1:0] ent;
    logic [DEPTH-1:0] vld;
    logic [DEPTH-1:0] hit;
    logic             query;

    always_comb begin
        st_acc.base = st_base_i;
        st_acc.off  = st_off_i;
        st_acc.size = st_size_i;
        ld_acc.base = ld_base_i;
        ld_acc.off  = ld_off_i;
        ld_acc.size = ld_size_i;
        query       = ld_vld_i && ld_desc_ok_i && (|vld);
    end

    sold_store_tab #(.DEPTH(DEPTH)) u_tab (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (grp_end_i),
        .wr_i     (st_vld_i && st_desc_ok_i),
        .wr_acc_i (st_acc),
        .ent_o    (ent),
        .vld_o    (vld)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        sold_cmp u_cmp (
            .en_i  (query && vld[g]),
            .st_i  (ent[g]),
            .ld_i  (ld_acc),
            .hit_o (hit[g])
        );
    end

    assign conflict_o = |hit;

    AST_CONF_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o |-> (ld_vld_i && ld_desc_ok_i)); // R6
    AST_CONF_NEEDS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o |-> (vld != '0)); // R6
    AST_CONF_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        grp_end_i |=> !conflict_o); // R7

endmodule

// File: tb/sim_store_overlap_det.sv
`timescale 1ns/1ps
module sim_store_overlap_det;
    import sold_pkg::*;

    localparam int DEPTH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grp_end, st_vld, st_ok, ld_vld, ld_ok;
    logic [BASE_W-1:0] st_base, ld_base;
    logic [OFF_W-1:0]  st_off, ld_off;
    logic [SIZE_W-1:0] st_size, ld_size;
    logic conflict;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int m_base [DEPTH];
    int m_off  [DEPTH];
    int m_size [DEPTH];
    int m_cnt = 0;

    always #4 clk = ~clk;

    store_overlap_det #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .grp_end_i(grp_end),
        .st_vld_i(st_vld), .st_desc_ok_i(st_ok), .st_base_i(st_base),
        .st_off_i(st_off), .st_size_i(st_size),
        .ld_vld_i(ld_vld), .ld_desc_ok_i(ld_ok), .ld_base_i(ld_base),
        .ld_off_i(ld_off), .ld_size_i(ld_size), .conflict_o(conflict)
    );

    function automatic bit exp_conf(int b, int o, int s, bit lv, bit lok);
        if (!lv || !lok) return 1'b0;
        for (int i = 0; i < m_cnt; i++) begin
            if (m_base[i] == b) begin
                if (m_off[i] == o) return 1'b1;
                if (m_off[i] < o) begin
                    if (m_off[i] + m_size[i] > o) return 1'b1;
                end else begin
                    if (o + s > m_off[i]) return 1'b1;
                end
            end
        end
        return 1'b0;
    endfunction

    task automatic step(input bit ge, input bit sv, input bit sok,
                        input int sb, input int so, input int ss,
                        input bit lv, input bit lok,
                        input int lb, input int lo, input int ls,
                        input string tag);
        bit e;
        @(negedge clk);
        grp_end = ge; st_vld = sv; st_ok = sok;
        st_base = BASE_W'(sb); st_off = OFF_W'(so); st_size = SIZE_W'(ss);
        ld_vld = lv; ld_ok = lok;
        ld_base = BASE_W'(lb); ld_off = OFF_W'(lo); ld_size = SIZE_W'(ls);
        #1;
        e = exp_conf(lb, lo, ls, lv, lok);
        checks++;
        if (conflict !== e) begin
            errors++;
            $display("FAIL %s: conflict=%b expected=%b", tag, conflict, e);
        end
        @(posedge clk);
        if (ge) m_cnt = 0;
        else if (sv && sok && m_cnt < DEPTH) begin
            m_base[m_cnt] = sb; m_off[m_cnt] = so; m_size[m_cnt] = ss;
            m_cnt++;
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: expired, expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        grp_end = 0; st_vld = 0; st_ok = 0; ld_vld = 0; ld_ok = 0;
        st_base = '0; st_off = '0; st_size = '0;
        ld_base = '0; ld_off = '0; ld_size = '0;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R6: reset state, no conflict
        step(0, 0, 0, 0, 0, 0, 1, 1, 1, 10, 4, "R6 reset");
        // R10: store and load in same cycle; store not yet visible
        step(0, 1, 1, 1, 10, 4, 1, 1, 1, 10, 4, "R10 same cycle");
        // R2: exact match with zero size
        step(0, 0, 0, 0, 0, 0, 1, 1, 1, 10, 0, "R2 exact");
        // R3: store below load
        step(0, 0, 0, 0, 0, 0, 1, 1, 1, 13, 1, "R3 overlap");
        step(0, 0, 0, 0, 0, 0, 1, 1, 1, 14, 1, "R3 adjacent");
        // R4: store at or above load
        step(0, 0, 0, 0, 0, 0, 1, 1, 1, 6, 4, "R4 adjacent");
        step(0, 0, 0, 0, 0, 0, 1, 1, 1, 6, 5, "R4 overlap");
        // R5: other base
        step(0, 0, 0, 0, 0, 0, 1, 1, 2, 10, 4, "R5 base differs");
        // R6: query gating
        step(0, 0, 0, 0, 0, 0, 1, 0, 1, 10, 4, "R6 no descriptor");
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, 10, 4, "R6 no load");
        // R9: store without descriptor
        step(0, 1, 0, 3, 0, 8, 0, 0, 0, 0, 0, "R9 store");
        step(0, 0, 0, 0, 0, 0, 1, 1, 3, 0, 1, "R9 not recorded");
        // R1: fill then drop
        step(0, 1, 1, 1, 20, 4, 0, 0, 0, 0, 0, "R1 fill");
        step(0, 1, 1, 1, 30, 4, 0, 0, 0, 0, 0, "R1 fill");
        step(0, 1, 1, 1, 40, 4, 0, 0, 0, 0, 0, "R1 fill");
        step(0, 1, 1, 1, 50, 4, 0, 0, 0, 0, 0, "R1 fifth");
        step(0, 0, 0, 0, 0, 0, 1, 1, 1, 50, 4, "R1 dropped");
        step(0, 0, 0, 0, 0, 0, 1, 1, 1, 40, 1, "R1 kept");
        // R7: group end beats simultaneous store
        step(1, 1, 1, 1, 60, 4, 0, 0, 0, 0, 0, "R7 end");
        step(0, 0, 0, 0, 0, 0, 1, 1, 1, 10, 4, "R7 cleared");
        step(0, 0, 0, 0, 0, 0, 1, 1, 1, 60, 4, "R7 store dropped");
        // R8: top of signed range
        step(0, 1, 1, 0, 32760, 16, 0, 0, 0, 0, 0, "R8 store");
        step(0, 0, 0, 0, 0, 0, 1, 1, 0, 32767, 1, "R8 no wrap");
        step(1, 1, 1, 0, -32768, 1, 0, 0, 0, 0, 0, "R8 end");
        step(0, 1, 1, 0, -32768, 1, 0, 0, 0, 0, 0, "R8 store neg");
        step(0, 0, 0, 0, 0, 0, 1, 1, 0, 32767, 255, "R8 far");
        step(0, 0, 0, 0, 0, 0, 1, 1, 0, -32768, 0, "R8 neg exact");
        step(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R7 end");

        // R3 R4 R5 random traffic in a narrow window
        for (int n = 0; n < 1500; n++) begin
            step(($urandom_range(7) == 0), ($urandom_range(2) != 0),
                 ($urandom_range(7) != 0), int'($urandom_range(2)),
                 int'($urandom_range(24)) - 12, int'($urandom_range(7)),
                 ($urandom_range(3) != 0), ($urandom_range(7) != 0),
                 int'($urandom_range(2)), int'($urandom_range(24)) - 12,
                 int'($urandom_range(7)), "R3 R4 random");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule